// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces four pulse-width modulated outputs that share one time base. A 16-bit programmable divider, preceded by a fixed divide-by-two stage, turns the system clock into a count tick. That tick advances a free-running 8-bit counter. Each channel compares its own 8-bit duty value against the counter, using a strict greater-than compare, to decide whether its output is at the active level. A single control bit chooses whether the active level is high or low for all four channels.

Software programs the block through a plain byte-wide write port. Two addresses hold the divisor bytes. Four addresses hold the channel duty values. One address holds the enable and polarity bits. New duty values are held in shadow storage and applied only at the counter wrap, so a period is never cut short. A new divisor is picked up when the running divider count expires.

Top module: `pwm4_prescaled`

## Requirements
- R1: While the reset input is low, all four outputs are low. After reset, every duty value, the divisor, the counter, the enable bit and the polarity bit are zero.
- R2: The counter advances by one on each tick, goes from 0 up to 255 and then back to 0, so one output period spans 256 ticks.
- R3: With polarity bit 0 and the block enabled, a channel output is high exactly when its applied duty value is greater than the counter, and low otherwise. Duty 0x00 therefore never goes high, and duty 0xFF is high for 255 of every 256 ticks. `pwm_out` is registered: it shows the compare result of the counter and duty state from one clock earlier.
- R4: Setting the polarity bit (bit 1 at address 6) inverts every output relative to R3. The change applies from the next clock, without waiting for a wrap.
- R5: With divisor value N, one tick occurs every 2·(N+1) clocks, so one output period lasts 512·(N+1) clocks.
- R6: The divisor is written as two bytes: the low byte at address 0 and the high byte at address 1.
- R7: A duty value written at addresses 2, 3, 4 and 5 (channels 0 to 3) is only applied when the counter wraps from 255 to 0.
- R8: A newly written divisor does not change the divider count in progress. The divider reloads from the newest divisor when its current count expires.
- R9: With the enable bit (bit 0 at address 6) cleared, the divider and the counter hold their values and every output sits at the inactive level, which is low for polarity 0 and high for polarity 1.
- R10: A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | 8 | Byte to write |
| pwm_out | output | 4 | Channel outputs, channel 0 in bit 0 |

## Verification
The bound checker checks the following on every clock: that the counter steps by exactly one per tick, that ticks never come on back-to-back clocks, that applied duty values only change at the 255-to-0 wrap, that a disabled block freezes its counter and drives the inactive level, and that a zero duty never produces an active pulse. Other properties need whole periods of stimulus, so only the bench scenarios can show them. These are the exact high-time per period for several duty values and both polarities, the period length for different divisor values written byte by byte, a divisor change taking effect only at expiry, and the write to the unused address having no effect. A behavioural reference model runs alongside and compares every output on every clock.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 8;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_INV_BIT = 1;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int CH_N   = 4,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [BYTE_W-1:0]             wr_data,
  output logic [DIV_W-1:0]              div_sh,
  output logic [CH_N-1:0][CNT_W-1:0]    duty_sh,
  output logic                          en_q,
  output logic                          inv_q
);
  localparam int DIV_BYTES = DIV_W / BYTE_W;
  localparam int DUTY_BASE = DIV_BYTES;
  localparam int CTRL_ADDR = DIV_BYTES + CH_N;

  logic [DIV_W-1:0]           div_d;
  logic [CH_N-1:0][CNT_W-1:0] duty_d;
  logic                       en_d;
  logic                       inv_d;

  always_comb begin
    div_d  = div_sh;
    duty_d = duty_sh;
    en_d   = en_q;
    inv_d  = inv_q;
    if (wr_en) begin
      for (int b = 0; b < DIV_BYTES; b++) begin
        if (wr_addr == ADDR_W'(b)) div_d[b*BYTE_W +: BYTE_W] = wr_data;
      end
      for (int c = 0; c < CH_N; c++) begin
        if (wr_addr == ADDR_W'(DUTY_BASE + c)) duty_d[c] = wr_data[CNT_W-1:0];
      end
      if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
        en_d  = wr_data[CTRL_EN_BIT];
        inv_d = wr_data[CTRL_INV_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sh  <= '0;
      duty_sh <= '0;
      en_q    <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      div_sh  <= div_d;
      duty_sh <= duty_d;
      en_q    <= en_d;
      inv_q   <= inv_d;
    end
  end
endmodule

// File: rtl/pwm4_prescale.sv
module pwm4_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic             half_q, half_d;
  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic             step;

  always_comb begin
    step   = en & half_q;
    tick   = step & (pcnt_q == '0);
    half_d = half_q;
    pcnt_d = pcnt_q;
    if (en) half_d = ~half_q;
    if (step) begin
      if (tick) pcnt_d = div;
      else      pcnt_d = pcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      half_q <= half_d;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
  import pwm4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] duty_sh,
  input  logic [CNT_W-1:0] cnt,
  input  logic             en,
  input  logic             inv,
  output logic [CNT_W-1:0] duty_act,
  output logic             out
);
  logic [CNT_W-1:0] duty_d;
  logic             out_d;
  logic             active;

  always_comb begin
    duty_d = duty_act;
    if (load) duty_d = duty_sh;
    active = (duty_act > cnt);
    out_d  = en ? (active ^ inv) : inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act <= '0;
      out      <= 1'b0;
    end else begin
      duty_act <= duty_d;
      out      <= out_d;
    end
  end
endmodule

// File: rtl/pwm4_prescaled.sv
module pwm4_prescaled
  import pwm4_pkg::*;
#(
  parameter int CH_N   = 4,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [CH_N-1:0]   pwm_out
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [1:0]                 rsync_q;
  logic                       rst_core_n;
  logic [DIV_W-1:0]           div_sh;
  logic [CH_N-1:0][CNT_W-1:0] duty_sh;
  logic [CH_N-1:0][CNT_W-1:0] duty_act;
  logic                       en_q;
  logic                       inv_q;
  logic                       tick;
  logic                       wrap;
  logic [CNT_W-1:0]           cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  pwm4_regs #(.CH_N(CH_N), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .div_sh  (div_sh),
    .duty_sh (duty_sh),
    .en_q    (en_q),
    .inv_q   (inv_q)
  );

  pwm4_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (en_q),
    .div   (div_sh),
    .tick  (tick)
  );

  always_comb begin
    wrap  = tick & (cnt_q == CNT_TOP);
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    pwm4_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .load     (wrap),
      .duty_sh  (duty_sh[c]),
      .cnt      (cnt_q),
      .en       (en_q),
      .inv      (inv_q),
      .duty_act (duty_act[c]),
      .out      (pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm4_prescaled_chk.sv
module pwm4_prescaled_chk
  import pwm4_pkg::*;
#(
  parameter int CH_N = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       en_q,
  input logic                       inv_q,
  input logic                       tick,
  input logic [CNT_W-1:0]           cnt_q,
  input logic [CH_N-1:0][CNT_W-1:0] duty_act,
  input logic [CH_N-1:0]            pwm_out
);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(cnt_q) + 8'd1));

  a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r7_duty_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt_q == 8'hFF) |=> $stable(duty_act));

  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(cnt_q));

  a_r9_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (pwm_out == {CH_N{$past(inv_q)}}));

  for (genvar c = 0; c < CH_N; c++) begin : g_zero
    a_r3_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !inv_q && duty_act[c] == '0) |=> !pwm_out[c]);
  end
endmodule

bind pwm4_prescaled pwm4_prescaled_chk #(.CH_N(CH_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .en_q     (en_q),
  .inv_q    (inv_q),
  .tick     (tick),
  .cnt_q    (cnt_q),
  .duty_act (duty_act),
  .pwm_out  (pwm_out)
);

// File: tb/pwm4_prescaled_test.sv
`timescale 1ns/1ps
module pwm4_prescaled_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] pwm_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit cmp_on = 0;
  int cmp_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm4_prescaled uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  // behavioural reference state
  int m_div, m_pcnt, m_cnt;
  int m_dsh[4];
  int m_dact[4];
  bit m_en, m_inv, m_half;
  bit m_out[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_pcnt = 0; m_cnt = 0; m_en = 0; m_inv = 0; m_half = 0;
      for (int i = 0; i < 4; i++) begin m_dsh[i] = 0; m_dact[i] = 0; m_out[i] = 0; end
    end else begin
      bit step, tk;
      step = m_en && m_half;
      tk = step && (m_pcnt == 0);
      for (int i = 0; i < 4; i++)
        m_out[i] = m_en ? ((m_dact[i] > m_cnt) ^ m_inv) : m_inv;
      if (m_en) m_half = !m_half;
      if (step) m_pcnt = tk ? m_div : m_pcnt - 1;
      if (tk) begin
        if (m_cnt == 255) for (int i = 0; i < 4; i++) m_dact[i] = m_dsh[i];
        m_cnt = (m_cnt + 1) % 256;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_div = (m_div & 32'hFF00) | wr_data;
          3'd1: m_div = (m_div & 32'h00FF) | (int'(wr_data) << 8);
          3'd2, 3'd3, 3'd4, 3'd5: m_dsh[wr_addr - 2] = wr_data;
          3'd6: begin m_en = wr_data[0]; m_inv = wr_data[1]; end
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      for (int i = 0; i < 4; i++) begin
        total++;
        if (pwm_out[i] !== m_out[i]) begin
          bad++; cmp_bad++;
          $display("FAIL R2 R3 R4 R5 R6 R7 R8 R9 R10 ch%0d cycle %0d: actual=%0b expected=%0b",
                   i, cyc, pwm_out[i], m_out[i]);
        end
      end
    end
    if (cyc > 200000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired: actual=%0d expected<=200000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic highs(input int n, output int h[4]);
    for (int i = 0; i < 4; i++) h[i] = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (pwm_out[i]) h[i]++;
    end
  endtask

  initial begin
    int h[4];
    int snap;
    idle(4);
    check("R1 outputs low in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    idle(4);
    check("R1 outputs low after reset", int'(pwm_out), 0);
    cmp_on = 1;

    // divisor 0, four duty patterns
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h40); wr(3'd4, 8'h80); wr(3'd5, 8'hFF);
    wr(3'd6, 8'h01);
    idle(600);
    highs(512, h);
    check("R3 duty 00 high time", h[0], 0);
    check("R3 duty 40 high time", h[1], 128);
    check("R2 duty 80 half period", h[2], 256);
    check("R3 duty FF high time", h[3], 510);

    // R7: mid-period duty change lands at wrap
    idle(100);
    wr(3'd3, 8'h10);
    idle(1100);
    highs(512, h);
    check("R7 new duty after wrap", h[1], 32);

    // R4: inverted polarity
    wr(3'd6, 8'h03);
    highs(512, h);
    check("R4 inverted duty 00", h[0], 512);
    check("R4 inverted duty 10", h[1], 480);
    check("R4 inverted duty FF", h[3], 2);

    // R10: write to unused address
    wr(3'd7, 8'hFF);
    highs(512, h);
    check("R10 unused address ch2", h[2], 256);
    check("R10 unused address ch0", h[0], 512);

    // R5 / R8: divisor 2
    wr(3'd6, 8'h01);
    wr(3'd0, 8'h02);
    idle(2000);
    highs(1536, h);
    check("R5 div2 duty 10", h[1], 96);
    check("R5 div2 duty 80", h[2], 768);
    check("R8 div2 duty FF", h[3], 1530);

    // R9: disable, both polarities
    wr(3'd6, 8'h00);
    highs(300, h);
    check("R9 disabled low ch3", h[3], 0);
    check("R9 disabled low ch2", h[2], 0);
    wr(3'd6, 8'h02);
    highs(300, h);
    check("R9 disabled inactive high ch0", h[0], 300);
    check("R9 disabled inactive high ch3", h[3], 300);

    // R6: high-byte divisor, tracked by the reference
    snap = cmp_bad;
    wr(3'd0, 8'h00); wr(3'd1, 8'h01);
    wr(3'd6, 8'h01);
    idle(3000);
    check("R6 two-byte divisor matches reference", cmp_bad - snap, 0);

    cmp_on = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule